// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Sticky Overflow

This unit performs signed 32-bit addition and subtraction that clamp to the representable range instead of wrapping. Two further operations first double the second operand, with its own clamping, and then add it to or subtract it from the first operand. A doubled operand can therefore saturate twice in one operation: once when it is doubled and once in the following add or subtract.

Each clamp raises a sticky overflow flag. The flag stays high across any number of later operations until software clears it. A routine can run a long series of operations and test the flag once at the end. The other condition codes are not touched by this unit.

Operands are presented with a valid strobe. The result and the updated flag are registered and appear one clock later.

Top module: `sat_addsub_unit`

## Requirements
- R1: With `in_op` = 00 (add), a valid operation whose true sum fits in 32 signed bits returns `in_a + in_b` exactly and leaves the flag unchanged.
- R2: A result above +2^31-1 (positive overflow) returns 0x7FFFFFFF and sets the flag.
- R3: A result below -2^31 (negative overflow) returns 0x80000000 and sets the flag.
- R4: With `in_op` = 01 (subtract), the result is `in_a - in_b` clamped as in R2/R3. This includes `in_b` = 0x80000000.
- R5: With `in_op` = 10 (double-add), the result is `in_a + sat(2*in_b)`. If the doubling clamps, the flag is set even when the final sum is in range.
- R6: With `in_op` = 11 (double-subtract), the result is `in_a - sat(2*in_b)`. Both the doubling and the subtraction may clamp.
- R7: The flag stays set through later operations that do not overflow and through idle cycles. Only `flag_clr` clears it, and it is never set without a valid operation.
- R8: When `flag_clr` is high in the same cycle as an overflowing operation, the clear wins and the flag reads 0 afterwards.
- R9: `out_valid` and `out_result` follow a valid operation by one clock. On cycles without `in_valid`, `out_valid` is 0 and `out_result` holds its last value.
- R10: After synchronous reset, `out_result` is 0, `out_valid` is 0 and the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation: 00 add, 01 sub, 10 double-add, 11 double-sub |
| in_a | input | W | First signed operand |
| in_b | input | W | Second signed operand (the doubled one) |
| flag_clr | input | 1 | Clear of the sticky overflow flag |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_result | output | W | Saturated result |
| sticky_flag | output | 1 | Sticky overflow flag |

## Verification
The sticky flag's set path and its clear path can fall in the same cycle. The bench provokes this by issuing an overflowing operation while `flag_clr` is high. It also clears in the cycle right after an overflow, and it clears together with a non-overflowing operation. Each case is judged against a behavioural model in which the clear takes priority. Every clock compares the flag, the result and the strobe, so a wrong priority shows up on the next edge.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } sat_op_e;
endpackage

// File: rtl/sat_doubler.sv
// Multiply by two with clamping to the signed range.
module sat_doubler #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    ovf = din[W-1] ^ din[W-2];
    if (!ovf) dout = {din[W-2:0], 1'b0};
    else      dout = din[W-1] ? MINV : MAXV;
  end
endmodule

// File: rtl/sat_addsub_core.sv
// One-bit-wider add or subtract, then clamp on sign disagreement.
module sat_addsub_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ea, eb, s;

  always_comb begin
    ea  = {a[W-1], a};
    eb  = {b[W-1], b};
    s   = sub ? (ea - eb) : (ea + eb);
    ovf = s[W] ^ s[W-1];
    if (ovf) res = s[W] ? MINV : MAXV;
    else     res = s[W-1:0];
  end
endmodule

// File: rtl/sticky_bit.sv
// Sticky status bit; clear beats set.
module sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         flag_clr,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         sticky_flag
);
  import sat_pkg::*;

  logic         do_dbl, do_sub;
  logic [W-1:0] dbl_val, opnd_b, core_res;
  logic         dbl_ovf, core_ovf, any_ovf;

  assign do_dbl = (in_op == OP_DADD) || (in_op == OP_DSUB);
  assign do_sub = (in_op == OP_SUB)  || (in_op == OP_DSUB);

  sat_doubler #(.W(W)) u_dbl (
    .din (in_b),
    .dout(dbl_val),
    .ovf (dbl_ovf)
  );

  assign opnd_b = do_dbl ? dbl_val : in_b;

  sat_addsub_core #(.W(W)) u_core (
    .a  (in_a),
    .b  (opnd_b),
    .sub(do_sub),
    .res(core_res),
    .ovf(core_ovf)
  );

  assign any_ovf = (do_dbl && dbl_ovf) || core_ovf;

  sticky_bit u_flag (
    .clk(clk),
    .rst(rst),
    .clr(flag_clr),
    .set(in_valid && any_ovf),
    .q  (sticky_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= core_res;
    end
  end

  // Checks on the behaviour at the ports.
  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result)));
  assert_clr_wins_R8: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> !sticky_flag);
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (sticky_flag && !flag_clr) |=> sticky_flag);
  assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (rst)
    (!sticky_flag && !in_valid) |=> !sticky_flag);
  assert_pos_add_sign_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ADD && !in_a[W-1] && !in_b[W-1]) |=> !out_result[W-1]);
  assert_neg_add_sign_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ADD && in_a[W-1] && in_b[W-1]) |=> out_result[W-1]);
endmodule

// File: tb/sat_addsub_unit_tb.sv
module sat_addsub_unit_tb;
  localparam int CLK_P = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   in_op;
  logic [W-1:0] in_a, in_b;
  logic         flag_clr;
  logic         out_valid;
  logic [W-1:0] out_result;
  logic         sticky_flag;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [W-1:0] m_res;
  logic         m_val, m_flag;

  always #(CLK_P/2) clk = ~clk;

  sat_addsub_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .flag_clr(flag_clr),
    .out_valid(out_valid), .out_result(out_result), .sticky_flag(sticky_flag)
  );

  function automatic longint clampv(longint v, inout bit o);
    if (v > 64'sd2147483647) begin o = 1'b1; return 64'sd2147483647; end
    if (v < -64'sd2147483648) begin o = 1'b1; return -64'sd2147483648; end
    return v;
  endfunction

  task automatic check(string tag);
    checks++;
    if (out_valid !== m_val || out_result !== m_res || sticky_flag !== m_flag) begin
      errors++;
      $display("FAIL %s: got valid=%0b res=%08h flag=%0b, expected valid=%0b res=%08h flag=%0b",
               tag, out_valid, out_result, sticky_flag, m_val, m_res, m_flag);
    end
  endtask

  // one clock: drive, advance the model, compare after the edge
  task automatic step(bit v, bit [1:0] op, bit [31:0] a, bit [31:0] b, bit clr, string tag);
    longint sa, sb, d, r;
    bit o;
    in_valid = v; in_op = op; in_a = a; in_b = b; flag_clr = clr;
    o  = 1'b0;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    d  = op[1] ? clampv(2 * sb, o) : sb;
    r  = op[0] ? (sa - d) : (sa + d);
    r  = clampv(r, o);
    @(posedge clk);
    #(CLK_P/4);
    m_val = v;
    if (v) m_res = r[31:0];
    if (clr) m_flag = 1'b0;
    else if (v && o) m_flag = 1'b1;
    check(tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] lfsr_a, lfsr_b;
    rst = 1'b1; in_valid = 0; in_op = 0; in_a = 0; in_b = 0; flag_clr = 0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    rst = 1'b0;
    m_res = '0; m_val = 1'b0; m_flag = 1'b0;
    check("R10 reset state");

    step(1, 2'b00, 32'd5, 32'd7, 0, "R1 add in range");
    step(1, 2'b00, 32'hFFFF_FFF0, 32'd3, 0, "R1 add negative in range");
    step(1, 2'b00, 32'h7FFF_FFFF, 32'd1, 0, "R2 positive overflow");
    step(1, 2'b00, 32'd1, 32'd1, 0, "R7 sticky holds over clean op");
    step(0, 2'b00, 32'd0, 32'd0, 0, "R9 idle holds result");
    step(0, 2'b00, 32'd0, 32'd0, 1, "R7 clear alone");
    step(1, 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R3 negative overflow");
    step(1, 2'b01, 32'd3, 32'd10, 1, "R8 clear with clean op");
    step(1, 2'b01, 32'd0, 32'h8000_0000, 0, "R4 subtract most negative");
    step(0, 2'b00, 32'd0, 32'd0, 1, "R7 clear after overflow");
    step(1, 2'b01, 32'h8000_0000, 32'd1, 1, "R8 clear beats set");
    step(1, 2'b10, 32'd100, 32'd21, 0, "R5 double-add in range");
    step(1, 2'b10, 32'h8000_0001, 32'h4000_0000, 0, "R5 doubling clamps, sum in range");
    step(0, 2'b00, 32'd0, 32'd0, 1, "R7 clear");
    step(1, 2'b10, 32'h7000_0000, 32'h3000_0000, 0, "R5 sum clamps");
    step(0, 2'b00, 32'd0, 32'd0, 1, "R7 clear");
    step(1, 2'b11, 32'd50, 32'd30, 0, "R6 double-sub in range");
    step(1, 2'b11, 32'd0, 32'h8000_0000, 0, "R6 both stages clamp");
    step(0, 2'b00, 32'd0, 32'd0, 1, "R7 clear");
    step(1, 2'b11, 32'hC000_0000, 32'h2000_0001, 0, "R6 subtract clamps");
    step(1, 2'b00, 32'd0, 32'd0, 0, "R1 zero add with flag held");

    lfsr_a = 32'h1234_5678; lfsr_b = 32'h9ABC_DEF1;
    for (int i = 0; i < 400; i++) begin
      lfsr_a = lfsr_a * 32'd1664525 + 32'd1013904223;
      lfsr_b = lfsr_b * 32'd22695477 + 32'd1;
      step(lfsr_a[3:0] != 4'h0, lfsr_b[1:0], lfsr_a, lfsr_b, lfsr_a[7:4] == 4'h3,
           "R4 R5 R6 R8 mixed stream");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule